// File: doc/BRIEF.md
# Polled Byte Port Controller

A peripheral controller that a host drives through four small memory-mapped registers on a single-cycle strobe bus. For output, the host loads a byte into the outbound data register. It then sets the command-pending and write flags in the control register. The controller marks itself busy, offers the byte to a byte-wide device port using valid/ready signalling, and waits for the device to take it. When the transfer ends, the controller clears the command-pending flag and the busy flag by itself. It clears the error flag if the transfer succeeded and sets it if the device reported a fault. The host can therefore run each byte as a simple polling loop on the busy flag.

For input, bytes arriving from the device fill a small receive FIFO that the host drains through the inbound data register. A status bit shows that bytes are waiting. A sticky overrun bit records any byte that was dropped because the FIFO was full. Line-mode settings held in the control register are driven out to the device side: duplex select, parity enable, 7/8-bit words and a 2-bit speed code. While a command is busy, the host cannot change them.

Top module: `byte_port_ctrl`

## Requirements
- R1: After synchronous reset every register reads 0x00, dev_tx_valid is 0 and all mode outputs are 0.
- R2: Register offsets are 0 inbound data (read), 1 outbound data (read/write), 2 status (read), 3 control (read/write). Status bits are busy=bit0, rx-available=bit1, error=bit2, overrun=bit3, with bits 7:4 reading 0. Control bits are command-pending=bit0, write=bit1, full-duplex=bit2, parity-enable=bit3, 8-bit-word=bit4, speed=bits 6:5, with bit7 reading 0.
- R3: Busy is still 0 in the cycle right after the control write that sets command-pending, and becomes 1 one clock later.
- R4: For a write command, dev_tx_valid rises together with busy and carries the outbound byte on dev_tx_data. It holds with the data stable until the clock edge where dev_tx_ready is 1.
- R5: One clock after the accepting edge, busy and command-pending return to 0 and error reads 0 when dev_tx_fail was 0. dev_tx_valid is already 0 during that cycle.
- R6: If dev_tx_fail is 1 at the accepting edge, error reads 1 after completion, while busy and command-pending are still cleared with the same timing as R5.
- R7: While busy is 1, host writes to the outbound data register and to the control register have no effect.
- R8: mode_full_duplex, mode_parity_en, mode_word8 and mode_speed follow control bits 2, 3, 4 and 6:5, and change only on an accepted control write.
- R9: Each clock with dev_rx_valid high pushes dev_rx_data into a 4-entry FIFO. A strobed read of offset 0 returns the oldest byte and removes it, and returns 0x00 when the FIFO is empty. Rx-available is 1 exactly when the FIFO holds a byte.
- R10: A byte that arrives while the FIFO is full, with no pop in the same cycle, is dropped and sets overrun. Overrun stays set until a strobed status read clears it.
- R11: A command with command-pending set and write clear shows busy for exactly one cycle, never raises dev_tx_valid, and completes as a success.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| host_sel | input | 1 | Single-cycle access strobe |
| host_we | input | 1 | 1 = write, 0 = read |
| host_addr | input | 2 | Register offset |
| host_wdata | input | 8 | Write data |
| host_rdata | output | 8 | Contents of the register at host_addr |
| dev_tx_valid | output | 1 | Outbound byte offered to the device |
| dev_tx_ready | input | 1 | Device takes the outbound byte |
| dev_tx_fail | input | 1 | Device reports a fault with the take |
| dev_tx_data | output | 8 | Outbound byte |
| dev_rx_valid | input | 1 | Inbound byte present |
| dev_rx_data | input | 8 | Inbound byte |
| mode_full_duplex | output | 1 | Duplex select |
| mode_parity_en | output | 1 | Parity enable |
| mode_word8 | output | 1 | 1 = 8-bit words, 0 = 7-bit |
| mode_speed | output | 2 | Speed code |

## Verification
Host reads are combinational on host_addr, so the bench sets the address just after a falling edge and samples there, with no clock edge in between. Strobed side effects (pop, overrun clear) land on the next rising edge. A control write takes effect on its rising edge. Busy and dev_tx_valid appear one edge later and completion one edge after acceptance, so the bench checks status at each of those falling edges in turn, never a few cycles later. Received bytes show up in rx-available at the falling edge that follows their push, and a seeded random mix of sends, faults, receive bursts and reads is compared with a queue model kept in the bench.

// File: rtl/bpc_pkg.sv
package bpc_pkg;

    localparam int DATA_W = 8;

    localparam logic [1:0] OFF_RXDATA = 2'd0;
    localparam logic [1:0] OFF_TXDATA = 2'd1;
    localparam logic [1:0] OFF_STATUS = 2'd2;
    localparam logic [1:0] OFF_CTRL   = 2'd3;

    typedef struct packed {
        logic       pad;
        logic [1:0] speed;
        logic       word8;
        logic       parity_en;
        logic       full_dup;
        logic       write_cmd;
        logic       cmd_rdy;
    } ctrl_reg_t;

    typedef struct packed {
        logic [3:0] pad;
        logic       overrun;
        logic       error;
        logic       avail;
        logic       busy;
    } status_reg_t;

    typedef enum logic [1:0] {
        XS_IDLE   = 2'd0,
        XS_SEND   = 2'd1,
        XS_FINISH = 2'd2
    } xfer_state_t;

    function automatic status_reg_t make_status(input logic busy, input logic avail,
                                                input logic err, input logic ovr);
        status_reg_t s;
        s = '0;
        s.busy    = busy;
        s.avail   = avail;
        s.error   = err;
        s.overrun = ovr;
        return s;
    endfunction

    function automatic ctrl_reg_t sanitize_ctrl(input logic [DATA_W-1:0] raw);
        ctrl_reg_t c;
        c = ctrl_reg_t'(raw);
        c.pad = 1'b0;
        return c;
    endfunction

endpackage

// File: rtl/bpc_rx_fifo.sv
module bpc_rx_fifo #(
    parameter int DW    = 8,
    parameter int DEPTH = 4
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          push,
    input  logic [DW-1:0] push_data,
    input  logic          pop,
    output logic [DW-1:0] head,
    output logic          empty,
    output logic          full
);
    localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CW = $clog2(DEPTH + 1);
    localparam logic [AW-1:0] LAST = AW'(DEPTH - 1);
    localparam logic [CW-1:0] FULL_CNT = CW'(DEPTH);

    logic [DW-1:0] mem [DEPTH];
    logic [AW-1:0] wr_ptr, rd_ptr;
    logic [CW-1:0] count;
    logic          do_push, do_pop;

    assign empty   = (count == '0);
    assign full    = (count == FULL_CNT);
    assign do_pop  = pop && !empty;
    assign do_push = push && (!full || do_pop);
    assign head    = empty ? '0 : mem[rd_ptr];

    always_ff @(posedge clk) begin
        if (rst) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            count  <= '0;
        end else begin
            if (do_push) begin
                wr_ptr <= (wr_ptr == LAST) ? '0 : wr_ptr + 1'b1;
            end
            if (do_pop) begin
                rd_ptr <= (rd_ptr == LAST) ? '0 : rd_ptr + 1'b1;
            end
            case ({do_push, do_pop})
                2'b10:   count <= count + 1'b1;
                2'b01:   count <= count - 1'b1;
                default: count <= count;
            endcase
        end
    end

    generate
        for (genvar i = 0; i < DEPTH; i++) begin : g_slot
            always_ff @(posedge clk) begin
                if (rst) begin
                    mem[i] <= '0;
                end else if (do_push && wr_ptr == AW'(i)) begin
                    mem[i] <= push_data;
                end
            end
        end
    endgenerate

endmodule

// File: rtl/bpc_xfer_fsm.sv
module bpc_xfer_fsm
    import bpc_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic cmd_rdy,
    input  logic write_cmd,
    input  logic tx_ready,
    input  logic tx_fail,
    output logic busy,
    output logic tx_valid,
    output logic done,
    output logic done_fail
);
    xfer_state_t state_q;
    logic        fail_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= XS_IDLE;
            fail_q  <= 1'b0;
        end else begin
            case (state_q)
                XS_IDLE: begin
                    if (cmd_rdy) begin
                        fail_q  <= 1'b0;
                        state_q <= write_cmd ? XS_SEND : XS_FINISH;
                    end
                end
                XS_SEND: begin
                    if (tx_ready) begin
                        fail_q  <= tx_fail;
                        state_q <= XS_FINISH;
                    end
                end
                XS_FINISH: state_q <= XS_IDLE;
                default:   state_q <= XS_IDLE;
            endcase
        end
    end

    assign busy      = (state_q != XS_IDLE);
    assign tx_valid  = (state_q == XS_SEND);
    assign done      = (state_q == XS_FINISH);
    assign done_fail = fail_q;

endmodule

// File: rtl/bpc_host_regs.sv
module bpc_host_regs
    import bpc_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              host_sel,
    input  logic              host_we,
    input  logic [1:0]        host_addr,
    input  logic [DATA_W-1:0] host_wdata,
    output logic [DATA_W-1:0] host_rdata,
    input  logic              busy,
    input  logic              done,
    input  logic              done_fail,
    input  logic [DATA_W-1:0] rx_head,
    input  logic              rx_empty,
    input  logic              rx_full,
    input  logic              rx_push,
    output logic              rx_pop,
    output ctrl_reg_t         ctrl,
    output logic [DATA_W-1:0] tx_byte,
    output logic              overrun
);
    ctrl_reg_t         ctrl_q;
    logic [DATA_W-1:0] dout_q;
    logic              err_q;
    logic              ovr_q;
    logic              wr_stb, rd_stb, ovr_evt;
    status_reg_t       stat;

    assign wr_stb  = host_sel && host_we;
    assign rd_stb  = host_sel && !host_we;
    assign rx_pop  = rd_stb && (host_addr == OFF_RXDATA);
    assign ovr_evt = rx_push && rx_full && !(rx_pop && !rx_empty);

    always_ff @(posedge clk) begin
        if (rst) begin
            ctrl_q <= '0;
            dout_q <= '0;
            err_q  <= 1'b0;
            ovr_q  <= 1'b0;
        end else begin
            if (wr_stb && !busy && host_addr == OFF_TXDATA) begin
                dout_q <= host_wdata;
            end
            if (wr_stb && !busy && host_addr == OFF_CTRL) begin
                ctrl_q <= sanitize_ctrl(host_wdata);
            end
            if (done) begin
                ctrl_q.cmd_rdy <= 1'b0;
                err_q          <= done_fail;
            end
            if (rd_stb && host_addr == OFF_STATUS) begin
                ovr_q <= 1'b0;
            end
            if (ovr_evt) begin
                ovr_q <= 1'b1;
            end
        end
    end

    assign stat = make_status(busy, !rx_empty, err_q, ovr_q);

    always_comb begin
        case (host_addr)
            OFF_RXDATA: host_rdata = rx_head;
            OFF_TXDATA: host_rdata = dout_q;
            OFF_STATUS: host_rdata = stat;
            default:    host_rdata = ctrl_q;
        endcase
    end

    assign ctrl    = ctrl_q;
    assign tx_byte = dout_q;
    assign overrun = ovr_q;

endmodule

// File: rtl/byte_port_ctrl.sv
module byte_port_ctrl
    import bpc_pkg::*;
#(
    parameter int RX_DEPTH = 4
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              host_sel,
    input  logic              host_we,
    input  logic [1:0]        host_addr,
    input  logic [DATA_W-1:0] host_wdata,
    output logic [DATA_W-1:0] host_rdata,
    output logic              dev_tx_valid,
    input  logic              dev_tx_ready,
    input  logic              dev_tx_fail,
    output logic [DATA_W-1:0] dev_tx_data,
    input  logic              dev_rx_valid,
    input  logic [DATA_W-1:0] dev_rx_data,
    output logic              mode_full_duplex,
    output logic              mode_parity_en,
    output logic              mode_word8,
    output logic [1:0]        mode_speed
);
    ctrl_reg_t         ctrl;
    logic              busy, done, done_fail;
    logic [DATA_W-1:0] rx_head;
    logic              rx_empty, rx_full, rx_pop, overrun;

    bpc_rx_fifo #(.DW(DATA_W), .DEPTH(RX_DEPTH)) u_fifo (
        .clk       (clk),
        .rst       (rst),
        .push      (dev_rx_valid),
        .push_data (dev_rx_data),
        .pop       (rx_pop),
        .head      (rx_head),
        .empty     (rx_empty),
        .full      (rx_full)
    );

    bpc_xfer_fsm u_fsm (
        .clk       (clk),
        .rst       (rst),
        .cmd_rdy   (ctrl.cmd_rdy),
        .write_cmd (ctrl.write_cmd),
        .tx_ready  (dev_tx_ready),
        .tx_fail   (dev_tx_fail),
        .busy      (busy),
        .tx_valid  (dev_tx_valid),
        .done      (done),
        .done_fail (done_fail)
    );

    bpc_host_regs u_regs (
        .clk        (clk),
        .rst        (rst),
        .host_sel   (host_sel),
        .host_we    (host_we),
        .host_addr  (host_addr),
        .host_wdata (host_wdata),
        .host_rdata (host_rdata),
        .busy       (busy),
        .done       (done),
        .done_fail  (done_fail),
        .rx_head    (rx_head),
        .rx_empty   (rx_empty),
        .rx_full    (rx_full),
        .rx_push    (dev_rx_valid),
        .rx_pop     (rx_pop),
        .ctrl       (ctrl),
        .tx_byte    (dev_tx_data),
        .overrun    (overrun)
    );

    assign mode_full_duplex = ctrl.full_dup;
    assign mode_parity_en   = ctrl.parity_en;
    assign mode_word8       = ctrl.word8;
    assign mode_speed       = ctrl.speed;

endmodule

// File: rtl/byte_port_ctrl_chk.sv
module byte_port_ctrl_chk (
    input logic       clk,
    input logic       rst,
    input logic       busy,
    input logic       cmd_rdy,
    input logic       tx_valid,
    input logic       tx_ready,
    input logic [7:0] tx_data,
    input logic [4:0] modes,
    input logic       rx_valid,
    input logic       rx_full,
    input logic       rx_pop,
    input logic       overrun
);
    // R4
    tx_needs_busy_chk: assert property (@(posedge clk) disable iff (rst)
        tx_valid |-> busy);

    // R4
    tx_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (tx_valid && !tx_ready) |=> (tx_valid && $stable(tx_data)));

    // R3
    accept_sets_busy_chk: assert property (@(posedge clk) disable iff (rst)
        (!busy && cmd_rdy) |=> busy);

    // R5
    finish_clears_cmd_chk: assert property (@(posedge clk) disable iff (rst)
        $fell(busy) |-> !cmd_rdy);

    // R7
    modes_frozen_chk: assert property (@(posedge clk) disable iff (rst)
        busy |=> $stable(modes));

    // R10
    overrun_set_chk: assert property (@(posedge clk) disable iff (rst)
        (rx_valid && rx_full && !rx_pop) |=> overrun);
endmodule

bind byte_port_ctrl byte_port_ctrl_chk u_chk (
    .clk      (clk),
    .rst      (rst),
    .busy     (busy),
    .cmd_rdy  (ctrl.cmd_rdy),
    .tx_valid (dev_tx_valid),
    .tx_ready (dev_tx_ready),
    .tx_data  (dev_tx_data),
    .modes    ({mode_speed, mode_word8, mode_parity_en, mode_full_duplex}),
    .rx_valid (dev_rx_valid),
    .rx_full  (rx_full),
    .rx_pop   (rx_pop),
    .overrun  (overrun)
);

// File: tb/byte_port_ctrl_bench.sv
module byte_port_ctrl_bench;
    localparam time CLK_P = 10;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       host_sel = 1'b0, host_we = 1'b0;
    logic [1:0] host_addr = 2'd0;
    logic [7:0] host_wdata = 8'd0;
    logic [7:0] host_rdata;
    logic       dev_tx_valid;
    logic       dev_tx_ready = 1'b0, dev_tx_fail = 1'b0;
    logic [7:0] dev_tx_data;
    logic       dev_rx_valid = 1'b0;
    logic [7:0] dev_rx_data = 8'd0;
    logic       mode_full_duplex, mode_parity_en, mode_word8;
    logic [1:0] mode_speed;

    int tests = 0;
    int fails = 0;
    logic [7:0] rxq[$];
    logic       exp_ovr = 1'b0;
    logic       exp_err = 1'b0;
    logic [7:0] exp_mode = 8'd0;

    always #(CLK_P/2) clk = ~clk;

    byte_port_ctrl u_byte_port_ctrl (
        .clk(clk), .rst(rst), .host_sel(host_sel), .host_we(host_we),
        .host_addr(host_addr), .host_wdata(host_wdata), .host_rdata(host_rdata),
        .dev_tx_valid(dev_tx_valid), .dev_tx_ready(dev_tx_ready),
        .dev_tx_fail(dev_tx_fail), .dev_tx_data(dev_tx_data),
        .dev_rx_valid(dev_rx_valid), .dev_rx_data(dev_rx_data),
        .mode_full_duplex(mode_full_duplex), .mode_parity_en(mode_parity_en),
        .mode_word8(mode_word8), .mode_speed(mode_speed)
    );

    function automatic logic [7:0] exp_status(input logic busy, input int n,
                                              input logic err, input logic ovr);
        return {4'b0, ovr, err, (n != 0), busy};
    endfunction

    function automatic logic [7:0] mode_bits(input logic [7:0] c);
        return {3'b0, c[6:5], c[4], c[3], c[2]};
    endfunction

    task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%02h expected=%02h at %0t", req, act, exp, $time);
        end
    endtask

    task automatic peek(input logic [1:0] a, output logic [7:0] d);
        host_addr = a;
        #1;
        d = host_rdata;
    endtask

    task automatic host_write(input logic [1:0] a, input logic [7:0] d);
        @(negedge clk);
        host_sel = 1'b1; host_we = 1'b1; host_addr = a; host_wdata = d;
        @(negedge clk);
        host_sel = 1'b0; host_we = 1'b0;
    endtask

    task automatic host_read(input logic [1:0] a, output logic [7:0] d);
        @(negedge clk);
        host_sel = 1'b1; host_we = 1'b0; host_addr = a;
        #1;
        d = host_rdata;
        @(negedge clk);
        host_sel = 1'b0;
    endtask

    task automatic check_modes(input string req);
        chk(req, {3'b0, mode_speed, mode_word8, mode_parity_en, mode_full_duplex},
            mode_bits(exp_mode));
    endtask

    // Full write command with exact-cycle checks.
    task automatic send_byte(input logic [7:0] d, input int lat, input logic fail,
                             input logic [7:0] mode, input logic poke);
        logic [7:0] r;
        host_write(2'd1, d);
        host_write(2'd3, mode | 8'h03);
        exp_mode = mode & 8'h7C;
        peek(2'd2, r);
        chk("R3 busy not yet", r, exp_status(1'b0, rxq.size(), exp_err, exp_ovr));
        @(negedge clk);
        peek(2'd2, r);
        chk("R3 busy set", r, exp_status(1'b1, rxq.size(), exp_err, exp_ovr));
        chk("R4 tx valid", {7'b0, dev_tx_valid}, 8'h01);
        chk("R4 tx data", dev_tx_data, d);
        if (poke) begin
            host_write(2'd1, ~d);
            host_write(2'd3, ~mode);
            chk("R7 tx data unchanged", dev_tx_data, d);
            peek(2'd1, r);
            chk("R7 data-out readback", r, d);
            peek(2'd3, r);
            chk("R7 control readback", r, exp_mode | 8'h03);
            check_modes("R7 modes unchanged");
        end else begin
            for (int i = 0; i < lat; i++) begin
                @(negedge clk);
                chk("R4 valid held", {7'b0, dev_tx_valid}, 8'h01);
                chk("R4 data stable", dev_tx_data, d);
            end
        end
        dev_tx_ready = 1'b1; dev_tx_fail = fail;
        @(negedge clk);
        dev_tx_ready = 1'b0; dev_tx_fail = 1'b0;
        chk("R5 valid dropped", {7'b0, dev_tx_valid}, 8'h00);
        peek(2'd2, r);
        chk("R5 still busy", r[0] ? 8'h01 : 8'h00, 8'h01);
        @(negedge clk);
        exp_err = fail;
        peek(2'd2, r);
        chk(fail ? "R6 error status" : "R5 done status", r,
            exp_status(1'b0, rxq.size(), exp_err, exp_ovr));
        peek(2'd3, r);
        chk("R5 cmd-ready cleared", r, exp_mode | 8'h02);
        check_modes("R8 modes");
    endtask

    task automatic rx_push(input logic [7:0] b);
        @(negedge clk);
        dev_rx_valid = 1'b1; dev_rx_data = b;
        @(negedge clk);
        dev_rx_valid = 1'b0;
        if (rxq.size() < 4) rxq.push_back(b);
        else exp_ovr = 1'b1;
    endtask

    task automatic read_data_in();
        logic [7:0] r, e;
        e = (rxq.size() != 0) ? rxq.pop_front() : 8'h00;
        host_read(2'd0, r);
        chk("R9 data-in", r, e);
    endtask

    task automatic read_status();
        logic [7:0] r;
        host_read(2'd2, r);
        chk("R10 status read", r, exp_status(1'b0, rxq.size(), exp_err, exp_ovr));
        exp_ovr = 1'b0;
    endtask

    initial begin
        #(CLK_P * 150000);
        fails++;
        $display("FAIL watchdog expired actual=running expected=finished");
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        logic [7:0] r;
        void'($urandom(32'h5EED_0042));
        repeat (3) @(negedge clk);
        rst = 1'b0;
        // R1 reset state
        for (int a = 0; a < 4; a++) begin
            peek(2'(a), r);
            chk("R1 reset register", r, 8'h00);
        end
        chk("R1 reset tx valid", {7'b0, dev_tx_valid}, 8'h00);
        check_modes("R1 reset modes");

        // R2/R8 readback with bit7 masked, no command
        host_write(2'd3, 8'hFC);
        exp_mode = 8'h7C;
        peek(2'd3, r);
        chk("R2 control readback", r, 8'h7C);
        check_modes("R8 modes after write");
        host_write(2'd1, 8'h3C);
        peek(2'd1, r);
        chk("R2 data-out readback", r, 8'h3C);
        peek(2'd2, r);
        chk("R2 status idle", r, 8'h00);

        // Directed sends
        send_byte(8'hA7, 0, 1'b0, 8'h14, 1'b0);
        send_byte(8'h5E, 3, 1'b1, 8'h68, 1'b0);
        send_byte(8'hC3, 0, 1'b0, 8'h24, 1'b1);

        // R11 command without write bit
        send_byte(8'h11, 1, 1'b1, 8'h00, 1'b0);
        host_write(2'd3, 8'h09);
        exp_mode = 8'h08;
        @(negedge clk);
        peek(2'd2, r);
        chk("R11 busy one cycle", r, exp_status(1'b1, 0, 1'b1, 1'b0));
        chk("R11 no tx valid", {7'b0, dev_tx_valid}, 8'h00);
        @(negedge clk);
        peek(2'd2, r);
        chk("R11 success clears error", r, 8'h00);
        exp_err = 1'b0;
        peek(2'd3, r);
        chk("R11 cmd cleared", r, 8'h08);

        // R9/R10 FIFO fill and overrun
        read_data_in();
        for (int i = 0; i < 5; i++) rx_push(8'h40 + 8'(i));
        peek(2'd2, r);
        chk("R10 overrun shown", r, 8'h0A);
        read_status();
        peek(2'd2, r);
        chk("R10 overrun cleared", r, 8'h02);
        for (int i = 0; i < 5; i++) read_data_in();
        peek(2'd2, r);
        chk("R9 fifo empty", r, 8'h00);

        // Random mix
        for (int it = 0; it < 120; it++) begin
            case ($urandom_range(0, 3))
                0: send_byte(8'($urandom), $urandom_range(0, 3), 1'($urandom),
                             8'($urandom) & 8'h7C, 1'b0);
                1: for (int k = 0; k < $urandom_range(1, 3); k++) rx_push(8'($urandom));
                2: read_data_in();
                default: read_status();
            endcase
        end

        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

endmodule